// File: doc/BRIEF.md
# E1 Timeslot Strobe and Gate Generator

This block keeps track of the bit position inside a 256-bit E1 frame: 32 timeslots of 8 bits each. From that position it produces two registered strobes that qualify the serial data stream. A channel clock pulses during the first bit of every timeslot. A channel gate is high during the timeslots that a 32-bit mask selects. The current timeslot and bit indices are also provided on the ports, so that logic nearby can steer data without a second counter.

A fixed-pattern mode replaces the mask with the layout used to carry a 1.544 Mbit/s payload inside an E1 frame. In that mode the gate is high for timeslots 1 to 15 and 17 to 25, and for exactly one extra bit at the start of timeslot 26. That gives 193 marked bits per frame. A frame-sync input realigns the counter. Without sync pulses the counter runs freely and wraps every 256 bits.

Top module: `e1_slot_strobe_gen`

## Requirements
- R1: Without frame sync, each clock advances the position by one bit. The bit index counts 0..7 and then the timeslot index increments. Timeslot 31 bit 7 is followed by timeslot 0 bit 0.
- R2: After a clock edge at which `frame_sync_i` is high, the outputs show timeslot 0, bit 0, from any previous position.
- R3: `chan_clk_o` is high exactly when the bit index shown is 0, in every timeslot and in both modes.
- R4: In mask mode (`g802_mode_i`=0), `chan_blk_o` is high for all 8 bits of timeslot n when bit n of `slot_mask_i` is 1 (bit 0 = timeslot 0), and low for all 8 bits when that bit is 0.
- R5: In fixed-pattern mode (`g802_mode_i`=1), `chan_blk_o` is high for every bit of timeslots 1 to 15, whatever the mask.
- R6: In fixed-pattern mode, `chan_blk_o` is high for every bit of timeslots 17 to 25.
- R7: In fixed-pattern mode, `chan_blk_o` is high for bit 0 of timeslot 26 only. It is low in timeslots 0 and 16, in bits 1 to 7 of timeslot 26, and in timeslots 27 to 31. This gives 193 high bits per frame.
- R8: While `rst_n` is low, the outputs show timeslot 31, bit 7, with both strobes low. The first clock edge after release without sync shows timeslot 0, bit 0.
- R9: The mode, mask and sync inputs are sampled at each clock edge. A change applies from the bit shown after the next edge, even in the middle of a frame.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Serial bit clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| frame_sync_i | input | 1 | Frame alignment: the next bit is timeslot 0 bit 0 |
| g802_mode_i | input | 1 | 1 selects the fixed 193-bit payload gate pattern |
| slot_mask_i | input | 32 | Per-timeslot gate enables, bit n = timeslot n |
| chan_clk_o | output | 1 | High during bit 0 of every timeslot |
| chan_blk_o | output | 1 | Channel gate for the current bit |
| slot_idx_o | output | 5 | Current timeslot index |
| bit_idx_o | output | 3 | Current bit index within the timeslot |

## Verification
A corrupted position counter shows on `slot_idx_o` and `bit_idx_o` at the next bit. It also shifts both strobes against the indices within the same cycle, because the strobes are registered from the same next position. A wrong gate decode appears only in the affected timeslot. The bench therefore walks whole frames under several masks and in fixed-pattern mode, and compares every bit of a frame together with the per-frame count of high gate bits, which must be 193 in fixed-pattern mode. Faults that mis-handle sync or the wrap at 256 appear within one frame of the event.

// File: rtl/e1_strobe_pkg.sv
package e1_strobe_pkg;
  localparam int unsigned SLOTS      = 32;
  localparam int unsigned SLOT_BITS  = 8;
  localparam int unsigned SLOT_W     = $clog2(SLOTS);
  localparam int unsigned BIT_W      = $clog2(SLOT_BITS);
  localparam int unsigned POS_W      = SLOT_W + BIT_W;
  localparam int unsigned PART_SLOT  = 26;

  typedef struct packed {
    logic [SLOT_W-1:0] slot;
    logic [BIT_W-1:0]  bitn;
  } frame_pos_t;

  // Timeslots fully gated in fixed-pattern mode
  function automatic logic [SLOTS-1:0] g802_full_slots();
    logic [SLOTS-1:0] v;
    for (int i = 0; i < SLOTS; i++) begin
      v[i] = ((i >= 1) && (i <= 15)) || ((i >= 17) && (i <= 25));
    end
    return v;
  endfunction
endpackage

// File: rtl/e1_pos_counter.sv
module e1_pos_counter
  import e1_strobe_pkg::*;
(
  input  logic       clk,
  input  logic       rst_n,
  input  logic       sync_i,
  output frame_pos_t pos_d_o,
  output frame_pos_t pos_q_o
);
  logic [POS_W-1:0] cnt_q;
  logic [POS_W-1:0] cnt_d;
  logic             cnt_en;

  assign cnt_en = 1'b1;

  always_comb begin
    if (sync_i) cnt_d = '0;
    else        cnt_d = cnt_q + 1'b1;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)      cnt_q <= '1;
    else if (cnt_en) cnt_q <= cnt_d;
  end

  assign pos_d_o = frame_pos_t'(cnt_d);
  assign pos_q_o = frame_pos_t'(cnt_q);

  // R1
  step_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !sync_i |=> cnt_q == $past(cnt_q) + 1'b1);
  // R1
  wrap_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (!sync_i && cnt_q == '1) |=> cnt_q == '0);
  // R2
  sync_chk: assert property (@(posedge clk) disable iff (!rst_n)
    sync_i |=> cnt_q == '0);
endmodule

// File: rtl/e1_gate_decode.sv
module e1_gate_decode
  import e1_strobe_pkg::*;
(
  input  frame_pos_t       pos_i,
  input  logic             g802_i,
  input  logic [SLOTS-1:0] mask_i,
  output logic             clk_strobe_o,
  output logic             gate_o
);
  localparam logic [SLOTS-1:0] G802_FULL = g802_full_slots();

  logic [SLOTS-1:0] slot_sel;
  logic             part_bit;

  for (genvar s = 0; s < SLOTS; s++) begin : g_slot
    assign slot_sel[s] = g802_i ? G802_FULL[s] : mask_i[s];
  end

  assign part_bit     = g802_i && (pos_i.slot == SLOT_W'(PART_SLOT)) &&
                        (pos_i.bitn == '0);
  assign clk_strobe_o = (pos_i.bitn == '0);
  assign gate_o       = slot_sel[pos_i.slot] | part_bit;
endmodule

// File: rtl/e1_slot_strobe_gen.sv
module e1_slot_strobe_gen
  import e1_strobe_pkg::*;
(
  input  logic              clk,
  input  logic              rst_n,
  input  logic              frame_sync_i,
  input  logic              g802_mode_i,
  input  logic [SLOTS-1:0]  slot_mask_i,
  output logic              chan_clk_o,
  output logic              chan_blk_o,
  output logic [SLOT_W-1:0] slot_idx_o,
  output logic [BIT_W-1:0]  bit_idx_o
);
  frame_pos_t pos_d;
  frame_pos_t pos_q;
  logic       clk_d, blk_d;
  logic       clk_q, blk_q;
  logic       strobe_en;

  assign strobe_en = 1'b1;

  e1_pos_counter u_cnt (
    .clk     (clk),
    .rst_n   (rst_n),
    .sync_i  (frame_sync_i),
    .pos_d_o (pos_d),
    .pos_q_o (pos_q)
  );

  e1_gate_decode u_dec (
    .pos_i        (pos_d),
    .g802_i       (g802_mode_i),
    .mask_i       (slot_mask_i),
    .clk_strobe_o (clk_d),
    .gate_o       (blk_d)
  );

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      clk_q <= 1'b0;
      blk_q <= 1'b0;
    end else if (strobe_en) begin
      clk_q <= clk_d;
      blk_q <= blk_d;
    end
  end

  assign chan_clk_o = clk_q;
  assign chan_blk_o = blk_q;
  assign slot_idx_o = pos_q.slot;
  assign bit_idx_o  = pos_q.bitn;

  // R3
  chclk_align_chk: assert property (@(posedge clk) disable iff (!rst_n)
    chan_clk_o == (bit_idx_o == '0));
  // R4
  mask_gate_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !g802_mode_i |=> chan_blk_o == $past(slot_mask_i[pos_d.slot]));
  // R7
  g802_idle_chk: assert property (@(posedge clk) disable iff (!rst_n)
    g802_mode_i |=> (((slot_idx_o == 5'd0) || (slot_idx_o == 5'd16) ||
                      (slot_idx_o >= 5'd27) ||
                      (slot_idx_o == 5'd26 && bit_idx_o != 3'd0)) -> !chan_blk_o));
  // R5
  g802_low_band_chk: assert property (@(posedge clk) disable iff (!rst_n)
    g802_mode_i |=> ((slot_idx_o >= 5'd1 && slot_idx_o <= 5'd15) -> chan_blk_o));
endmodule

// File: tb/e1_slot_strobe_gen_tb.sv
module e1_slot_strobe_gen_tb;
  localparam int CLK_PERIOD = 10;
  localparam int NVEC = 6;
  // {fixed-pattern mode, mask}
  localparam logic [32:0] VEC [NVEC] = '{
    {1'b0, 32'h0000_0000},
    {1'b0, 32'hFFFF_FFFF},
    {1'b0, 32'h8000_0001},
    {1'b0, 32'hA5A5_5A5A},
    {1'b1, 32'h0000_0000},
    {1'b1, 32'hFFFF_FFFF}
  };

  logic        clk = 1'b0;
  logic        rst_n;
  logic        frame_sync_i;
  logic        g802_mode_i;
  logic [31:0] slot_mask_i;
  logic        chan_clk_o, chan_blk_o;
  logic [4:0]  slot_idx_o;
  logic [2:0]  bit_idx_o;

  int checks = 0;
  int errors = 0;
  bit done = 0;

  e1_slot_strobe_gen u_dut (
    .clk(clk), .rst_n(rst_n), .frame_sync_i(frame_sync_i),
    .g802_mode_i(g802_mode_i), .slot_mask_i(slot_mask_i),
    .chan_clk_o(chan_clk_o), .chan_blk_o(chan_blk_o),
    .slot_idx_o(slot_idx_o), .bit_idx_o(bit_idx_o)
  );

  always #(CLK_PERIOD/2) clk = ~clk;

  function automatic bit exp_gate(bit g, logic [31:0] m, int s, int b);
    if (g) return (s >= 1 && s <= 15) || (s >= 17 && s <= 25) || (s == 26 && b == 0);
    return m[s];
  endfunction

  task automatic check(string req, int act, int exp);
    checks++;
    if (act != exp) begin
      errors++;
      $display("FAIL %s: actual=%0d expected=%0d", req, act, exp);
    end
  endtask

  task automatic step();
    @(posedge clk);
    #2;
  endtask

  task automatic check_bit(string req, bit g, logic [31:0] m, int s, int b);
    check({req, " slot"}, slot_idx_o, s);
    check({req, " bit"}, bit_idx_o, b);
    check({req, " R3 chclk"}, chan_clk_o, (b == 0));
    check({req, " gate"}, chan_blk_o, exp_gate(g, m, s, b));
  endtask

  initial begin
    #(CLK_PERIOD * 150000);
    if (!done) begin
      errors++; checks++;
      $display("FAIL watchdog: actual=hung expected=done");
      $display("Result: errors=%0d of %0d checks", errors, checks);
      $finish;
    end
  end

  initial begin
    int hi;
    rst_n = 1'b0; frame_sync_i = 1'b0; g802_mode_i = 1'b0; slot_mask_i = '0;
    #(CLK_PERIOD * 3 + 2);
    // R8 reset state
    check("R8 reset slot", slot_idx_o, 31);
    check("R8 reset bit", bit_idx_o, 7);
    check("R8 reset chclk", chan_clk_o, 0);
    check("R8 reset blk", chan_blk_o, 0);
    @(negedge clk); rst_n = 1'b1;
    step();
    check("R8 first bit slot", slot_idx_o, 0);
    check("R8 first bit idx", bit_idx_o, 0);

    // Vector table: sync then whole frame per entry (R1..R7)
    for (int v = 0; v < NVEC; v++) begin
      g802_mode_i = VEC[v][32];
      slot_mask_i = VEC[v][31:0];
      frame_sync_i = 1'b1;
      step();
      frame_sync_i = 1'b0;
      hi = 0;
      for (int k = 0; k < 256; k++) begin
        check_bit(VEC[v][32] ? "R5/R6/R7" : "R4", VEC[v][32], VEC[v][31:0], k / 8, k % 8);
        hi += chan_blk_o;
        step();
      end
      // R1 wrap to slot 0 bit 0
      check("R1 wrap slot", slot_idx_o, 0);
      check("R1 wrap bit", bit_idx_o, 0);
      if (VEC[v][32]) check("R7 count", hi, 193);
      else            check("R4 count", hi, 8 * $countones(VEC[v][31:0]));
    end

    // R2 mid-frame sync
    g802_mode_i = 1'b0; slot_mask_i = 32'h0000_0001;
    repeat (77) step();
    check("R2 pre slot", slot_idx_o, 77 / 8);
    frame_sync_i = 1'b1;
    step();
    frame_sync_i = 1'b0;
    check("R2 sync slot", slot_idx_o, 0);
    check("R2 sync bit", bit_idx_o, 0);
    check("R2 sync blk", chan_blk_o, 1);

    // R9 mode change mid-frame: now slot 0 bit 0; advance to slot 3 bit 4
    repeat (28) step();
    check("R9 before slot", slot_idx_o, 3);
    check("R9 before blk", chan_blk_o, 0);
    g802_mode_i = 1'b1;
    check("R9 no change before edge", chan_blk_o, 0);
    step();
    check("R9 after edge blk", chan_blk_o, 1);
    slot_mask_i = 32'h0000_0008; g802_mode_i = 1'b0;
    step();
    check("R9 back to mask", chan_blk_o, 1);
    slot_mask_i = 32'h0;
    step();
    check("R9 mask cleared", chan_blk_o, 0);

    done = 1;
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end
endmodule